// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block derives the 16x oversampling enable for a UART transmitter and receiver from a reference clock. The divisor has an integer part and a fractional part. The integer part sets the base number of reference cycles between enable pulses. The fractional part, in 1/64 steps, stretches some periods by one cycle, so that the average period equals integer + fraction/64 reference cycles. The enable pulse then runs at 16 times the programmed baud rate.

Software writes the integer and fractional values through two write strobes into staging registers. A staged value becomes the working divisor only when the serial engines report that no character is in flight. The period counter and the fraction accumulator restart at that moment, so a character is never sent or sampled at a mix of two rates. A working divisor that is out of range raises a flag and stops the pulses. Out of range means an integer part of zero, or the top integer value combined with a nonzero fraction.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset both working divisor fields are zero, so `invalid_o` is 1 and `tick_o` stays 0 until a valid divisor is applied.
- R2: With integer part N ≥ 1 and fraction 0, `tick_o` is high for exactly one reference cycle every N cycles. N = 1 gives a pulse on every cycle.
- R3: With fraction F (0..63), every pulse-to-pulse interval is N or N+1 cycles. Any 64 consecutive intervals add up to exactly 64·N + F cycles.
- R4: A working integer part of 0 drives `invalid_o` to 1 and suppresses every pulse, whatever the fraction.
- R5: A working integer part of 0xFFFF with a nonzero fraction is invalid. A working integer part of 0xFFFF with fraction 0 is valid.
- R6: While `busy_i` is 1, a divisor write does not change the running rate. Pulses continue at the previous interval.
- R7: A pending write is applied in the first cycle in which `busy_i` is 0. The counter restarts there. With `busy_i` dropped in cycle d, the first pulse at the new integer rate N appears in cycle d+N, and the next one appears in cycle d+2N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_val_i | input | 16 | Integer divisor value to stage |
| int_we_i | input | 1 | Write strobe for the integer value |
| frac_val_i | input | 6 | Fractional divisor value to stage, in 1/64 units |
| frac_we_i | input | 1 | Write strobe for the fractional value |
| busy_i | input | 1 | High while a character is being sent or received |
| tick_o | output | 1 | One-cycle 16x oversampling enable |
| invalid_o | output | 1 | Working divisor is out of range |

## Verification
The assertions check the following on every cycle:
- No pulse appears while the divisor is flagged invalid.
- Both range rules raise the flag.
- The working divisor stays frozen while a character is in flight.
- A pending value is loaded in the first idle cycle.
- Every interval between pulses is the integer part or one more.

The bench scenarios cover what a single-cycle property cannot express:
- The exact 64·N + F sum over 64 fractional periods.
- The precise cycle of the first pulse after a deferred update.
- The reset state.
- That a write made during a character leaves the observed rate untouched.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
  localparam int unsigned DIV_INT_W  = 16;
  localparam int unsigned DIV_FRAC_W = 6;
endpackage

// File: rtl/baud_shadow_regs.sv
module baud_shadow_regs #(
  parameter int unsigned INT_W  = uart_baud_pkg::DIV_INT_W,
  parameter int unsigned FRAC_W = uart_baud_pkg::DIV_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INT_W-1:0]  int_val_i,
  input  logic              int_we_i,
  input  logic [FRAC_W-1:0] frac_val_i,
  input  logic              frac_we_i,
  input  logic              busy_i,
  output logic [INT_W-1:0]  shd_int_o,
  output logic [FRAC_W-1:0] shd_frac_o,
  output logic [INT_W-1:0]  act_int_o,
  output logic [FRAC_W-1:0] act_frac_o,
  output logic              pending_o,
  output logic              apply_o
);
  logic [INT_W-1:0]  shd_int_q, act_int_q;
  logic [FRAC_W-1:0] shd_frac_q, act_frac_q;
  logic              pending_q;

  assign apply_o = pending_q & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_int_q  <= '0;
      shd_frac_q <= '0;
    end else begin
      if (int_we_i)  shd_int_q  <= int_val_i;
      if (frac_we_i) shd_frac_q <= frac_val_i;
    end
  end

  // a write in the apply cycle re-arms the pending flag for the next idle cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_q <= 1'b0;
    else         pending_q <= int_we_i | frac_we_i | (pending_q & busy_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_int_q  <= '0;
      act_frac_q <= '0;
    end else if (apply_o) begin
      act_int_q  <= shd_int_q;
      act_frac_q <= shd_frac_q;
    end
  end

  assign shd_int_o  = shd_int_q;
  assign shd_frac_o = shd_frac_q;
  assign act_int_o  = act_int_q;
  assign act_frac_o = act_frac_q;
  assign pending_o  = pending_q;
endmodule

// File: rtl/baud_div_check.sv
module baud_div_check #(
  parameter int unsigned INT_W  = uart_baud_pkg::DIV_INT_W,
  parameter int unsigned FRAC_W = uart_baud_pkg::DIV_FRAC_W
) (
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic              invalid_o
);
  localparam logic [INT_W-1:0] INT_MAX = '1;

  logic int_zero, top_with_frac;

  assign int_zero      = (div_int_i == '0);
  assign top_with_frac = (div_int_i == INT_MAX) && (div_frac_i != '0);
  assign invalid_o     = int_zero | top_with_frac;
endmodule

// File: rtl/baud_frac_counter.sv
module baud_frac_counter #(
  parameter int unsigned INT_W  = uart_baud_pkg::DIV_INT_W,
  parameter int unsigned FRAC_W = uart_baud_pkg::DIV_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic              tick_o
);
  localparam int unsigned LEN_W = INT_W + 1;

  logic [INT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              extra_q;
  logic [LEN_W-1:0]  period_len, last_idx;
  logic [FRAC_W:0]   acc_sum;
  logic              at_end;

  // current period is stretched by one cycle when the previous add carried
  assign period_len = {1'b0, div_int_i} + LEN_W'(extra_q);
  assign last_idx   = period_len - LEN_W'(1);
  assign at_end     = ({1'b0, cnt_q} == last_idx);
  assign acc_sum    = {1'b0, acc_q} + {1'b0, div_frac_i};
  assign tick_o     = at_end & ~clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else if (at_end) begin
      cnt_q   <= '0;
      acc_q   <= acc_sum[FRAC_W-1:0];
      extra_q <= acc_sum[FRAC_W];
    end else begin
      cnt_q   <= cnt_q + INT_W'(1);
    end
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int unsigned INT_W  = uart_baud_pkg::DIV_INT_W,
  parameter int unsigned FRAC_W = uart_baud_pkg::DIV_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INT_W-1:0]  int_val_i,
  input  logic              int_we_i,
  input  logic [FRAC_W-1:0] frac_val_i,
  input  logic              frac_we_i,
  input  logic              busy_i,
  output logic              tick_o,
  output logic              invalid_o
);
  logic [INT_W-1:0]  shd_int, act_int;
  logic [FRAC_W-1:0] shd_frac, act_frac;
  logic              pending, apply, div_bad, cnt_clear;

  baud_shadow_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .int_val_i  (int_val_i),
    .int_we_i   (int_we_i),
    .frac_val_i (frac_val_i),
    .frac_we_i  (frac_we_i),
    .busy_i     (busy_i),
    .shd_int_o  (shd_int),
    .shd_frac_o (shd_frac),
    .act_int_o  (act_int),
    .act_frac_o (act_frac),
    .pending_o  (pending),
    .apply_o    (apply)
  );

  baud_div_check #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_check (
    .div_int_i  (act_int),
    .div_frac_i (act_frac),
    .invalid_o  (div_bad)
  );

  assign cnt_clear = apply | div_bad;

  baud_frac_counter #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (cnt_clear),
    .div_int_i  (act_int),
    .div_frac_i (act_frac),
    .tick_o     (tick_o)
  );

  assign invalid_o = div_bad;
endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk #(
  parameter int unsigned INT_W  = uart_baud_pkg::DIV_INT_W,
  parameter int unsigned FRAC_W = uart_baud_pkg::DIV_FRAC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              tick_o,
  input logic              invalid_o,
  input logic              pending,
  input logic [INT_W-1:0]  shd_int,
  input logic [FRAC_W-1:0] shd_frac,
  input logic [INT_W-1:0]  act_int,
  input logic [FRAC_W-1:0] act_frac
);
  localparam logic [INT_W-1:0] INT_MAX = '1;

  logic [INT_W:0] gap_q;
  logic           armed_q;
  logic           reload;

  assign reload = pending & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      gap_q   <= (tick_o || reload) ? '0 : gap_q + (INT_W+1)'(1);
      if (reload || invalid_o) armed_q <= 1'b0;
      else if (tick_o)         armed_q <= 1'b1;
    end
  end

  p_no_tick_invalid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !tick_o);

  p_zero_int_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_int == '0) |-> invalid_o);

  p_top_frac_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act_int == INT_MAX) && (act_frac != '0)) |-> invalid_o);

  p_hold_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(act_int) && $stable(act_frac)));

  p_apply_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending && !busy_i) |=> ((act_int == $past(shd_int)) && (act_frac == $past(shd_frac))));

  p_interval_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && armed_q) |->
      (((gap_q + (INT_W+1)'(1)) == {1'b0, act_int}) ||
       ((gap_q + (INT_W+1)'(1)) == ({1'b0, act_int} + (INT_W+1)'(1)))));
endmodule

bind uart_baud_gen uart_baud_gen_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy_i),
  .tick_o    (tick_o),
  .invalid_o (invalid_o),
  .pending   (pending),
  .shd_int   (shd_int),
  .shd_frac  (shd_frac),
  .act_int   (act_int),
  .act_frac  (act_frac)
);

// File: tb/test_uart_baud_gen.sv
module test_uart_baud_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] int_val = '0;
  logic        int_we = 1'b0;
  logic [5:0]  frac_val = '0;
  logic        frac_we = 1'b0;
  logic        busy = 1'b0;
  logic        tick, invalid;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int tick_cnt = 0;
  int prev_t  = 0;
  bit have_prev = 0;
  bit sb_en   = 0;
  bit done    = 0;
  int exp_q[$];
  int times_q[$];

  uart_baud_gen i_uart_baud_gen (
    .clk_i(clk), .rst_ni(rst_n), .int_val_i(int_val), .int_we_i(int_we),
    .frac_val_i(frac_val), .frac_we_i(frac_we), .busy_i(busy),
    .tick_o(tick), .invalid_o(invalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: record ticks, pop expected intervals from the scoreboard
  always @(negedge clk) begin
    if (rst_n && tick) begin
      tick_cnt++;
      times_q.push_back(cyc);
      if (sb_en && have_prev && exp_q.size() > 0) begin
        int e;
        int d;
        e = exp_q.pop_front();
        d = cyc - prev_t;
        check(d == e, "R2/R6 interval", d, e);
      end
      have_prev = 1;
      prev_t = cyc;
    end
  end

  task automatic wr_both(input int iv, input int fv);
    @(negedge clk);
    int_val = 16'(iv); frac_val = 6'(fv); int_we = 1'b1; frac_we = 1'b1;
    @(negedge clk);
    int_we = 1'b0; frac_we = 1'b0;
  endtask

  task automatic wr_int(input int iv);
    @(negedge clk);
    int_val = 16'(iv); int_we = 1'b1;
    @(negedge clk);
    int_we = 1'b0;
  endtask

  task automatic wr_frac(input int fv);
    @(negedge clk);
    frac_val = 6'(fv); frac_we = 1'b1;
    @(negedge clk);
    frac_we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: arm the scoreboard with n expected intervals
  task automatic expect_period(input int per, input int n);
    @(posedge clk); #1;
    exp_q.delete();
    have_prev = 0;
    for (int i = 0; i < n; i++) exp_q.push_back(per);
    sb_en = 1;
  endtask

  task automatic clear_times();
    @(posedge clk); #1;
    times_q.delete();
    tick_cnt = 0;
  endtask

  task automatic frac_run(input int n, input int f);
    int bad;
    wr_both(n, f);
    wait_cyc(4);
    clear_times();
    wait_cyc(66 * (n + 1) + 10);
    check(times_q.size() >= 65, "R3 tick count", times_q.size(), 65);
    if (times_q.size() >= 65) begin
      check(times_q[64] - times_q[0] == 64 * n + f, "R3 sum of 64", times_q[64] - times_q[0], 64 * n + f);
      bad = 0;
      for (int k = 1; k < 65; k++) begin
        int d;
        d = times_q[k] - times_q[k-1];
        if (d != n && d != n + 1) bad++;
      end
      check(bad == 0, "R3 interval bounds", bad, 0);
    end
  endtask

  initial begin
    int d0;
    int first_t;
    int second_t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    wait_cyc(2);
    check(invalid == 1'b1, "R1 invalid after reset", invalid, 1);
    check(tick == 1'b0, "R1 tick after reset", tick, 0);
    wait_cyc(50);
    check(tick_cnt == 0, "R1 no ticks before valid divisor", tick_cnt, 0);

    // R2 integer only
    wr_both(5, 0);
    wait_cyc(4);
    check(invalid == 1'b0, "R2 valid divisor", invalid, 0);
    expect_period(5, 6);
    wait_cyc(45);
    check(exp_q.size() == 0, "R2 period 5 consumed", exp_q.size(), 0);
    sb_en = 0;

    wr_both(1, 0);
    wait_cyc(4);
    expect_period(1, 10);
    wait_cyc(20);
    check(exp_q.size() == 0, "R2 period 1 consumed", exp_q.size(), 0);
    sb_en = 0;

    // R3 fractional
    frac_run(3, 21);
    frac_run(2, 63);
    frac_run(10, 1);

    // R4 zero integer
    wr_both(0, 0);
    wait_cyc(4);
    check(invalid == 1'b1, "R4 zero integer invalid", invalid, 1);
    clear_times();
    wait_cyc(100);
    check(tick_cnt == 0, "R4 no ticks", tick_cnt, 0);
    wr_both(0, 32);
    wait_cyc(4);
    check(invalid == 1'b1, "R4 zero integer with fraction", invalid, 1);

    // R5 top integer
    wr_both(16'hFFFF, 1);
    wait_cyc(4);
    check(invalid == 1'b1, "R5 top with fraction invalid", invalid, 1);
    clear_times();
    wait_cyc(50);
    check(tick_cnt == 0, "R5 no ticks", tick_cnt, 0);
    wr_frac(0);
    wait_cyc(4);
    check(invalid == 1'b0, "R5 top with zero fraction valid", invalid, 0);

    // R6 hold while busy, R7 apply at boundary
    wr_both(4, 0);
    wait_cyc(4);
    @(negedge clk);
    busy = 1'b1;
    wr_int(9);
    wait_cyc(2);
    expect_period(4, 8);
    wait_cyc(40);
    check(exp_q.size() == 0, "R6 old rate kept while busy", exp_q.size(), 0);
    check(invalid == 1'b0, "R6 still valid while busy", invalid, 0);
    sb_en = 0;
    @(negedge clk);
    busy = 1'b0;
    d0 = cyc;
    wait_cyc(30);
    first_t = -1;
    second_t = -1;
    foreach (times_q[k]) begin
      if (times_q[k] > d0) begin
        if (first_t < 0) first_t = times_q[k];
        else if (second_t < 0) second_t = times_q[k];
      end
    end
    check(first_t == d0 + 9, "R7 first tick after release", first_t - d0, 9);
    check(second_t == d0 + 18, "R7 second tick after release", second_t - d0, 18);

    // R1 reset mid-run clears working divisor
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(2);
    check(invalid == 1'b1, "R1 invalid after second reset", invalid, 1);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule